// File: doc/BRIEF.md
# SPI Flash Page-Program Engine

This block is the command side of a small serial flash memory, as seen from its SPI pins. A host selects the device, shifts an opcode in MSB first and, for a program command, a 24-bit address and one or more data bytes. The engine gathers the data bytes into a 256-byte page buffer. When chip-select is released cleanly on a byte boundary, it runs a self-timed program cycle that merges the buffer into a behavioural byte array.

The SPI pins are asynchronous to the system clock. They pass through a synchronizer and are edge-detected, so the system clock must run at least eight times faster than SCK. The engine also answers a write-enable command and a status-read command. The status read can be polled while a program cycle is running.

An array inspection port lets the surrounding model read any byte of the array combinationally. A three-bit protection input fences off the upper pages of the array.

Top module: `spipp_engine`

## Requirements
- R1: After reset every array byte reads 0xFF, the write-enable latch is 0, BUSY is 0 and `spi_miso` is 0.
- R2: Opcode 0x06 followed by chip-select rising after exactly 8 bits sets the write-enable latch. Any other bit count leaves the latch unchanged.
- R3: Opcode 0x02, then three address bytes (MSB first), then at least one data byte starts a program only if chip-select rises after a whole number of bytes. Any other release, or a release with no data byte, leaves the array and the latch unchanged.
- R4: A program command issued while the write-enable latch is 0 changes no array byte.
- R5: Address bits [7:0] give the first byte offset in the page. Bits [9:8] give the page. Bits [23:10] are ignored. A write past offset 255 continues at offset 0 of the same page.
- R6: When more than 256 data bytes are sent, each later byte replaces the earlier byte at the same wrapped offset. Only the last value for each offset is programmed.
- R7: Programming sets each addressed byte to the old byte AND the buffered byte. Bytes that were not addressed are unchanged.
- R8: A valid program start raises BUSY for exactly `TPP_CYCLES` system clocks and clears the write-enable latch.
- R9: Opcode 0x05 returns the status byte MSB first, repeated for as long as chip-select stays low. Bit 0 is BUSY, bit 1 is the write-enable latch, and the other bits are 0. Output bits change after SCK falls. The command is answered while BUSY is 1. `spi_miso` is 0 when the device is deselected.
- R10: While BUSY is 1, opcodes 0x02 and 0x06 are ignored.
- R11: `prot_bp` of 0 protects nothing. A value of 1 protects page 3, 2 protects pages 2 and 3, and 3 to 7 protect every page. A program aimed at a protected page changes nothing and leaves the write-enable latch set.
- R12: SCK idling low (mode 0) and SCK idling high (mode 3) both work. MOSI is sampled on rising SCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, asynchronous |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | SPI data into the device |
| spi_miso | output | 1 | SPI data out of the device (status) |
| prot_bp | input | 3 | Block-protection level |
| peek_addr | input | MEM_AW (10) | Array inspection address |
| peek_data | output | 8 | Array byte at `peek_addr` |

## Verification
The assertions assume that chip-select stays at its new level for at least four system clocks after a change. They also assume that each SCK phase lasts at least four system clocks, so every pin change is seen by the synchronizer in order. With these assumptions, a program start or a write-enable set always coincides with chip-select already high at the pin. The bench drives SCK with five-clock half periods. It holds chip-select steady for at least five clocks on each side of every change, and it changes MOSI only while SCK is low.

// File: rtl/spipp_pkg.sv
// Shared constants and types for the SPI page-program engine.
// Assumes a 256-byte page; every other size is a module parameter.
package spipp_pkg;
    localparam int PAGE_OFS_W = 8;
    localparam int PAGE_BYTES = 1 << PAGE_OFS_W;

    localparam logic [7:0] OPC_PROGRAM = 8'h02;
    localparam logic [7:0] OPC_STATUS  = 8'h05;
    localparam logic [7:0] OPC_WR_EN   = 8'h06;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_DATA,
        PH_STATUS,
        PH_WR_EN,
        PH_DISCARD
    } phase_t;
endpackage

// File: rtl/spipp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes every pin is held for longer than STAGES system clocks.
module spipp_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= d;
                end
            end else begin : g_next
                // Later flops settle the sampled value.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spipp_cmd.sv
// SPI command decoder: assembles bytes on rising SCK, decodes the opcode,
// collects address and data into the page buffer, owns the write-enable
// latch, checks protection when chip-select is released, and shifts the
// status byte out after falling SCK.
// Assumes synchronized pins and an SCK phase of several system clocks.
module spipp_cmd
    import spipp_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sck_s,
    input  logic                     cs_n_s,
    input  logic                     mosi_s,
    input  logic                     busy,
    input  logic [2:0]               prot_bp,
    input  logic [PAGE_OFS_W-1:0]    buf_rd_idx,
    output logic [7:0]               buf_rd_data,
    output logic                     buf_rd_vld,
    output logic                     wel,
    output logic                     prog_start,
    output logic [MEM_AW-PAGE_OFS_W-1:0] prog_page,
    output logic                     miso
);
    localparam int PIDX_W    = MEM_AW - PAGE_OFS_W;
    localparam int NUM_PAGES = 1 << PIDX_W;

    logic                  sck_q, cs_q;
    logic                  sck_rise, sck_fall, cs_rise;
    phase_t                phase;
    logic [2:0]            bit_cnt;
    logic [6:0]            shreg;
    logic [7:0]            byte_in;
    logic [MEM_AW-1:0]     addr;
    logic [1:0]            addr_cnt;
    logic [PAGE_OFS_W-1:0] ofs;
    logic                  got_data;
    logic [7:0]            page_buf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] page_vld;
    logic                  data_wr;
    logic [PIDX_W-1:0]     cur_page;
    logic                  page_locked;
    logic [7:0]            status_byte;
    logic [6:0]            stat_sh;
    logic [2:0]            out_cnt;

    assign sck_rise    = sck_s & ~sck_q;
    assign sck_fall    = ~sck_s & sck_q;
    assign cs_rise     = cs_n_s & ~cs_q;
    assign byte_in     = {shreg, mosi_s};
    assign cur_page    = addr[MEM_AW-1:PAGE_OFS_W];
    assign data_wr     = ~cs_n_s & sck_rise & (bit_cnt == 3'd7) & (phase == PH_DATA);
    assign status_byte = {6'b0, wel, busy};
    assign buf_rd_data = page_buf[buf_rd_idx];
    assign buf_rd_vld  = page_vld[buf_rd_idx];

    // Edge-detect history of synchronized SCK and chip-select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
        end
    end

    // Protection decode: level k>0 fences off the top 2^(k-1) pages.
    always_comb begin
        page_locked = 1'b0;
        if (prot_bp != 3'd0) begin
            if (int'(prot_bp) - 1 >= PIDX_W)
                page_locked = 1'b1;
            else
                page_locked = (int'(cur_page) >= NUM_PAGES - (1 << (int'(prot_bp) - 1)));
        end
    end

    // Command sequencer, write-enable latch and program launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_OPCODE;
            bit_cnt    <= 3'd0;
            shreg      <= 7'd0;
            addr       <= '0;
            addr_cnt   <= 2'd0;
            ofs        <= '0;
            got_data   <= 1'b0;
            page_vld   <= '0;
            wel        <= 1'b0;
            prog_start <= 1'b0;
            prog_page  <= '0;
        end else begin
            prog_start <= 1'b0;
            if (cs_n_s) begin
                phase    <= PH_OPCODE;
                bit_cnt  <= 3'd0;
                addr_cnt <= 2'd0;
                got_data <= 1'b0;
                if (cs_rise && bit_cnt == 3'd0) begin
                    if (phase == PH_WR_EN)
                        wel <= 1'b1;
                    if (phase == PH_DATA && got_data && !page_locked && !busy) begin
                        prog_start <= 1'b1;
                        prog_page  <= cur_page;
                        wel        <= 1'b0;
                    end
                end
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                shreg   <= {shreg[5:0], mosi_s};
                if (bit_cnt == 3'd7) begin
                    unique case (phase)
                        PH_OPCODE: begin
                            if (byte_in == OPC_PROGRAM) begin
                                if (busy || !wel) begin
                                    phase <= PH_DISCARD;
                                end else begin
                                    phase    <= PH_ADDR;
                                    page_vld <= '0;
                                end
                            end else if (byte_in == OPC_STATUS) begin
                                phase <= PH_STATUS;
                            end else if (byte_in == OPC_WR_EN) begin
                                phase <= busy ? PH_DISCARD : PH_WR_EN;
                            end else begin
                                phase <= PH_DISCARD;
                            end
                        end
                        PH_ADDR: begin
                            addr     <= MEM_AW'({addr, byte_in});
                            addr_cnt <= addr_cnt + 2'd1;
                            if (addr_cnt == 2'd2) begin
                                phase <= PH_DATA;
                                ofs   <= byte_in;
                            end
                        end
                        PH_DATA: begin
                            page_vld[ofs] <= 1'b1;
                            ofs           <= ofs + 1'b1;
                            got_data      <= 1'b1;
                        end
                        PH_WR_EN:   phase <= PH_DISCARD;
                        PH_STATUS:  phase <= PH_STATUS;
                        PH_DISCARD: phase <= PH_DISCARD;
                        default:    phase <= PH_DISCARD;
                    endcase
                end
            end
        end
    end

    // Page buffer storage; later bytes at a wrapped offset replace earlier ones.
    always_ff @(posedge clk) begin
        if (data_wr)
            page_buf[ofs] <= byte_in;
    end

    // Status shifter: reloads the live status at each byte, drives after falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso    <= 1'b0;
            stat_sh <= 7'd0;
            out_cnt <= 3'd0;
        end else if (cs_n_s || phase != PH_STATUS) begin
            miso    <= 1'b0;
            out_cnt <= 3'd0;
        end else if (sck_fall) begin
            if (out_cnt == 3'd0) begin
                miso    <= status_byte[7];
                stat_sh <= status_byte[6:0];
            end else begin
                miso    <= stat_sh[6];
                stat_sh <= {stat_sh[5:0], 1'b0};
            end
            out_cnt <= out_cnt + 3'd1;
        end
    end
endmodule

// File: rtl/spipp_array.sv
// Behavioural byte array plus the self-timed program cycle. During the
// first PAGE_BYTES cycles of BUSY it walks the page buffer and ANDs every
// valid byte into the array; BUSY lasts TPP_CYCLES clocks in total.
// Assumes TPP_CYCLES >= PAGE_BYTES and that the buffer holds still while busy.
module spipp_array
    import spipp_pkg::*;
#(
    parameter int MEM_AW     = 10,
    parameter int TPP_CYCLES = 2000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          prog_start,
    input  logic [MEM_AW-PAGE_OFS_W-1:0]  prog_page,
    input  logic [7:0]                    buf_data,
    input  logic                          buf_vld,
    output logic [PAGE_OFS_W-1:0]         buf_idx,
    output logic                          busy,
    input  logic [MEM_AW-1:0]             peek_addr,
    output logic [7:0]                    peek_data
);
    localparam int MEM_BYTES = 1 << MEM_AW;
    localparam int PIDX_W    = MEM_AW - PAGE_OFS_W;
    localparam int CNT_RAW   = $clog2(TPP_CYCLES + 1);
    localparam int CNT_W     = (CNT_RAW > PAGE_OFS_W + 1) ? CNT_RAW : PAGE_OFS_W + 1;

    logic [7:0]        mem [MEM_BYTES];
    logic [CNT_W-1:0]  tick;
    logic [PIDX_W-1:0] pg;
    logic              walk;

    assign buf_idx   = tick[PAGE_OFS_W-1:0];
    assign walk      = busy && (tick < CNT_W'(PAGE_BYTES));
    assign peek_data = mem[peek_addr];

    // Program-cycle timer and BUSY flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            tick <= '0;
            pg   <= '0;
        end else if (prog_start) begin
            busy <= 1'b1;
            tick <= '0;
            pg   <= prog_page;
        end else if (busy) begin
            if (tick == CNT_W'(TPP_CYCLES - 1))
                busy <= 1'b0;
            else
                tick <= tick + 1'b1;
        end
    end

    // Array storage: erased at reset, bits only cleared by programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++)
                mem[i] <= 8'hFF;
        end else if (walk && buf_vld) begin
            mem[{pg, buf_idx}] <= mem[{pg, buf_idx}] & buf_data;
        end
    end
endmodule

// File: rtl/spipp_engine.sv
// Top of the SPI page-program engine: synchronizes the SPI pins, decodes
// commands and runs the array program cycle.
// Assumes clk is at least eight times faster than spi_sck.
module spipp_engine
    import spipp_pkg::*;
#(
    parameter int MEM_AW      = 10,
    parameter int TPP_CYCLES  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [2:0]        prot_bp,
    input  logic [MEM_AW-1:0] peek_addr,
    output logic [7:0]        peek_data
);
    localparam int PIDX_W = MEM_AW - PAGE_OFS_W;

    logic                  sck_s, cs_n_s, mosi_s;
    logic                  busy, wel, prog_start;
    logic [PIDX_W-1:0]     prog_page;
    logic [PAGE_OFS_W-1:0] buf_idx;
    logic [7:0]            buf_data;
    logic                  buf_vld;

    spipp_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_cs_n, spi_mosi}),
        .q     ({sck_s, cs_n_s, mosi_s})
    );

    spipp_cmd #(
        .MEM_AW (MEM_AW)
    ) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_s       (sck_s),
        .cs_n_s      (cs_n_s),
        .mosi_s      (mosi_s),
        .busy        (busy),
        .prot_bp     (prot_bp),
        .buf_rd_idx  (buf_idx),
        .buf_rd_data (buf_data),
        .buf_rd_vld  (buf_vld),
        .wel         (wel),
        .prog_start  (prog_start),
        .prog_page   (prog_page),
        .miso        (spi_miso)
    );

    spipp_array #(
        .MEM_AW     (MEM_AW),
        .TPP_CYCLES (TPP_CYCLES)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_start (prog_start),
        .prog_page  (prog_page),
        .buf_data   (buf_data),
        .buf_vld    (buf_vld),
        .buf_idx    (buf_idx),
        .busy       (busy),
        .peek_addr  (peek_addr),
        .peek_data  (peek_data)
    );
endmodule

// File: rtl/spipp_checker.sv
// Property checker for spipp_engine, attached by bind below.
// Assumes chip-select holds each level for at least four system clocks.
module spipp_checker #(
    parameter int TPP_CYCLES = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic wel,
    input logic prog_start,
    input logic spi_cs_n,
    input logic spi_miso
);
    int busy_len;

    // Counts consecutive BUSY cycles for the program-time window check.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R8: a program start raises BUSY and drops the write-enable latch.
    a_r8_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> (busy && !wel));

    // R8: BUSY lasts exactly the programmed number of cycles.
    a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == TPP_CYCLES));

    // R10: no second program may launch during a cycle.
    a_r10_no_restart_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !prog_start);

    // R3: a program launches only once chip-select is released.
    a_r3_start_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> spi_cs_n);

    // R2: the write-enable latch is set only on release of chip-select.
    a_r2_wel_sets_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> spi_cs_n);

    // R9: the data output is quiet while deselected.
    a_r9_miso_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);
endmodule

bind spipp_engine spipp_checker #(.TPP_CYCLES(TPP_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .wel        (wel),
    .prog_start (prog_start),
    .spi_cs_n   (spi_cs_n),
    .spi_miso   (spi_miso)
);

// File: tb/spipp_engine_bench.sv
// Self-checking bench: vector table of program commands, then directed tests.
module spipp_engine_bench;
    localparam int MEM_AW = 10;
    localparam int TPP    = 2000;
    localparam int MEMB   = 1 << MEM_AW;

    typedef struct packed {
        logic        m3;
        logic [23:0] addr;
        logic [9:0]  n;
        logic [7:0]  seed;
        logic [2:0]  bp;
        logic        we;
    } vec_t;

    // R3 R5 R12 R11 R11 R5 R6 R4 R11 R7
    localparam vec_t VECS [9] = '{
        '{1'b0, 24'h000000, 10'd4,   8'h11, 3'd0, 1'b1},
        '{1'b1, 24'h0001FE, 10'd5,   8'h22, 3'd0, 1'b1},
        '{1'b0, 24'h000310, 10'd3,   8'h33, 3'd1, 1'b1},
        '{1'b0, 24'h000210, 10'd3,   8'h44, 3'd1, 1'b1},
        '{1'b1, 24'hFF0120, 10'd2,   8'h55, 3'd2, 1'b1},
        '{1'b0, 24'h000280, 10'd260, 8'h66, 3'd0, 1'b1},
        '{1'b0, 24'h000005, 10'd2,   8'h77, 3'd0, 1'b0},
        '{1'b1, 24'h000040, 10'd2,   8'h88, 3'd3, 1'b1},
        '{1'b0, 24'h000002, 10'd3,   8'h5A, 3'd0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sck = 1'b0;
    logic              cs_n = 1'b1;
    logic              mosi = 1'b0;
    logic              miso;
    logic [2:0]        bp = 3'd0;
    logic [MEM_AW-1:0] peek = '0;
    logic [7:0]        peek_d;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic exp_wel = 1'b0;
    logic m3 = 1'b0;
    logic [7:0] exp_mem [MEMB];

    always #5 clk = ~clk;

    spipp_engine #(.MEM_AW(MEM_AW), .TPP_CYCLES(TPP)) u_spipp_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (sck),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .prot_bp   (bp),
        .peek_addr (peek),
        .peek_data (peek_d)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] dat(input logic [7:0] seed, input int i);
        return seed + 8'(i * 37);
    endfunction

    function automatic logic is_prot(input logic [2:0] lvl, input int page);
        if (lvl == 3'd0) return 1'b0;
        if (lvl >= 3'd3) return 1'b1;
        return page >= 4 - (1 << (int'(lvl) - 1));
    endfunction

    task automatic cs_begin();
        @(negedge clk);
        sck = m3;
        #50;
        cs_n = 1'b0;
        #50;
    endtask

    task automatic cs_end();
        if (!m3) sck = 1'b0;
        #50;
        cs_n = 1'b1;
        #200;
    endtask

    task automatic send_bits(input int n, input logic [31:0] v, output logic [31:0] rx);
        rx = '0;
        for (int b = n - 1; b >= 0; b--) begin
            if (sck) sck = 1'b0;
            mosi = v[b];
            #50;
            rx = {rx[30:0], miso};
            sck = 1'b1;
            #50;
        end
    endtask

    task automatic wren();
        logic [31:0] rx;
        cs_begin();
        send_bits(8, 32'h06, rx);
        cs_end();
    endtask

    task automatic read_status(output logic [15:0] two);
        logic [31:0] rx;
        cs_begin();
        send_bits(24, 32'h050000, rx);
        cs_end();
        two = rx[15:0];
    endtask

    // Sends a program command; extra_bits > 0 appends a partial byte.
    task automatic page_prog(input logic [23:0] a, input int n, input logic [7:0] seed,
                             input int extra_bits);
        logic [31:0] rx;
        cs_begin();
        send_bits(32, {8'h02, a}, rx);
        for (int i = 0; i < n; i++) send_bits(8, {24'h0, dat(seed, i)}, rx);
        if (extra_bits > 0) send_bits(extra_bits, 32'hF, rx);
        cs_end();
    endtask

    task automatic model_prog(input logic [23:0] a, input int n, input logic [7:0] seed);
        logic [7:0] tb [256];
        logic       tv [256];
        int         page;
        for (int j = 0; j < 256; j++) begin tb[j] = 8'h00; tv[j] = 1'b0; end
        page = int'(a[9:8]);
        for (int i = 0; i < n; i++) begin
            tb[(int'(a[7:0]) + i) % 256] = dat(seed, i);
            tv[(int'(a[7:0]) + i) % 256] = 1'b1;
        end
        for (int j = 0; j < 256; j++)
            if (tv[j]) exp_mem[page * 256 + j] = exp_mem[page * 256 + j] & tb[j];
    endtask

    task automatic check_mem(input string tag);
        int   bad = -1;
        logic [7:0] got = 8'h00;
        for (int a = 0; a < MEMB; a++) begin
            peek = a[MEM_AW-1:0];
            #1;
            if (bad < 0 && peek_d !== exp_mem[a]) begin bad = a; got = peek_d; end
        end
        if (bad < 0) check(tag, 32'h0, 32'h0);
        else check($sformatf("%s array[%0d]", tag, bad), {24'h0, got}, {24'h0, exp_mem[bad]});
    endtask

    task automatic wait_prog();
        repeat (TPP + 50) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] st;
        for (int a = 0; a < MEMB; a++) exp_mem[a] = 8'hFF;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);

        // R1: reset state
        @(negedge clk);
        check("R1 miso idle", {31'h0, miso}, 32'h0);
        check_mem("R1 erased array");
        read_status(st);
        check("R1 status after reset", {24'h0, st[15:8]}, 32'h00);

        // R2: nine-bit write enable is rejected, eight-bit accepted
        begin
            logic [31:0] rx;
            cs_begin();
            send_bits(9, 32'h0C, rx);
            cs_end();
        end
        read_status(st);
        check("R2 nine bits leave latch clear", {24'h0, st[15:8]}, 32'h00);
        m3 = 1'b1;
        wren();
        exp_wel = 1'b1;
        read_status(st);
        check("R2 R12 write enable in mode 3", {24'h0, st[15:8]}, 32'h02);
        m3 = 1'b0;

        // R3: release mid-byte and release with no data both abort
        page_prog(24'h000100, 1, 8'h00, 4);
        wait_prog();
        check_mem("R3 mid-byte release");
        page_prog(24'h000100, 0, 8'h00, 0);
        wait_prog();
        check_mem("R3 release without data");
        read_status(st);
        check("R3 latch kept after abort", {24'h0, st[15:8]}, 32'h02);

        // Vector table walk: R3 R4 R5 R6 R7 R11 R12
        for (int v = 0; v < 9; v++) begin
            vec_t  t = VECS[v];
            string tg = $sformatf("vec%0d R3 R4 R5 R6 R7 R11", v);
            m3 = t.m3;
            bp = t.bp;
            if (t.we) begin wren(); exp_wel = 1'b1; end
            page_prog(t.addr, int'(t.n), t.seed, 0);
            wait_prog();
            if (exp_wel && !is_prot(t.bp, int'(t.addr[9:8]))) begin
                model_prog(t.addr, int'(t.n), t.seed);
                exp_wel = 1'b0;
            end
            check_mem(tg);
            read_status(st);
            check({tg, " status"}, {24'h0, st[15:8]}, {30'h0, exp_wel, 1'b0});
        end
        m3 = 1'b0;
        bp = 3'd0;

        // R8 R9 R10: status while busy, write enable ignored while busy
        wren();
        page_prog(24'h000300, 2, 8'h99, 0);
        model_prog(24'h000300, 2, 8'h99);
        read_status(st);
        check("R8 R9 first status byte while busy", {24'h0, st[15:8]}, 32'h01);
        check("R9 repeated status byte while busy", {24'h0, st[7:0]}, 32'h01);
        wren();
        wait_prog();
        read_status(st);
        check("R8 R10 busy ended, write enable ignored", {24'h0, st[15:8]}, 32'h00);
        check_mem("R7 R8 program while busy");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule